// File: doc/BRIEF.md
# Lookahead Adder-Subtractor with Signed Overflow

This block is a purely combinational two's-complement adder-subtractor for a datapath of parameterised width. Its carries are not passed bit to bit. Each bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). Inside every 4-bit group, each carry is the flat sum of products of the lower generate and propagate terms and the group's carry-in. Between groups, the carry passes through each group's own generate and propagate pair, so the width may be any multiple of four.

Subtraction complements the second operand with an XOR against the subtract control, and sets the carry into bit 0. An increment mode replaces the second operand with zero and sets the carry-in, which gives A+1. Increment takes precedence over subtract. The carry out of the top bit is reported unchanged in every mode. In subtract mode it therefore reads one when no borrow took place. Signed overflow is the XOR of the carry into the top bit and the carry out of it.

Top module: `lasub_cla_addsub`

## Requirements
- R1: With inc_i=0 and sub_i=0, sum_o equals (a_i + b_i) mod 2^W and cout_o equals bit W of the unsigned sum.
- R2: With inc_i=0 and sub_i=1, sum_o equals (a_i - b_i) mod 2^W, and cout_o is 1 exactly when a_i >= b_i as unsigned numbers (no borrow).
- R3: In add mode, ovf_o is 1 exactly when a_i and b_i have the same sign bit and sum_o has the other one. In subtract mode, ovf_o is 1 exactly when a_i and b_i differ in sign and sum_o's sign differs from a_i's.
- R4: With inc_i=1, sum_o equals (a_i + 1) mod 2^W and cout_o is 1 exactly when a_i is all ones, whatever the value of b_i.
- R5: inc_i=1 overrides sub_i. With both set, the result is a_i + 1.
- R6: In increment mode, ovf_o is 1 only for a_i equal to the largest positive value (top bit 0, all others 1).
- R7: A carry generated in one 4-bit group reaches every higher group. For example, 0x0FFF + 0x0001 gives 0x1000 at W=16, and 0xFFFF + 0x0001 gives 0x0000 with cout_o=1.
- R8: The width parameter W may be any multiple of 4, and the same behaviour holds at W=4 and at W=16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand, ignored in increment mode |
| sub_i | input | 1 | 1 selects A minus B |
| inc_i | input | 1 | 1 selects A plus one, with priority over sub_i |
| sum_o | output | W | Sum, difference or incremented value |
| cout_o | output | 1 | Carry out of the top bit (1 means no borrow when subtracting) |
| ovf_o | output | 1 | Signed overflow |

## Verification
At W=4, every operand pair is applied in both add and subtract mode. This separates an error in any single carry product term from a correct one, and it checks the sign-rule overflow against the carry-based one in all cases. At W=16, a table of directed vectors exercises the following cases:
- carries that cross group boundaries;
- all-propagate operands with no generate;
- the extreme signed values;
- equal operands in subtract mode;
- increment with a nonzero b_i, and increment together with subtract.

These cases show that the group chain is correct, that the borrow sense of cout_o is right, and that b_i is suppressed. Random wide vectors then cover mixed patterns of generate and propagate across all four groups.

// File: rtl/lasub_pkg.sv
// Package: shared constants and the flat carry expansion used by the
// lookahead groups. Assumes groups of exactly GRP_W bits.
package lasub_pkg;

    localparam int GRP_W = 4;

    typedef logic [GRP_W-1:0] grp_vec_t;

    // Carry out of bit position j of a group, written as a flat OR of
    // products: every generate at or below j propagated up to j, plus the
    // group carry-in propagated through bits 0..j.
    function automatic logic flat_carry(input grp_vec_t g, input grp_vec_t p,
                                        input logic cin, input int j);
        logic acc;
        logic prod;
        acc = 1'b0;
        for (int i = 0; i < GRP_W; i++) begin
            if (i <= j) begin
                prod = g[i];
                for (int k = 0; k < GRP_W; k++) begin
                    if (k > i && k <= j) prod = prod & p[k];
                end
                acc = acc | prod;
            end
        end
        prod = cin;
        for (int k = 0; k < GRP_W; k++) begin
            if (k <= j) prod = prod & p[k];
        end
        return acc | prod;
    endfunction

endpackage

// File: rtl/lasub_operand_prep.sv
// Operand conditioning: picks the effective second operand and the carry
// into bit 0 from the mode controls. Increment has priority over subtract.
// Assumes nothing about the operand values.
module lasub_operand_prep #(
    parameter int W = 16
) (
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         inc_i,
    output logic [W-1:0] bx_o,
    output logic         cin_o
);

    // Select zero, inverted or plain B, and the matching carry-in.
    always_comb begin
        if (inc_i) begin
            bx_o  = '0;
            cin_o = 1'b1;
        end else begin
            bx_o  = b_i ^ {W{sub_i}};
            cin_o = sub_i;
        end
    end

endmodule

// File: rtl/lasub_cla_group.sv
// One 4-bit lookahead group: from per-bit generate/propagate and the group
// carry-in it forms the three inner carries in flat sum-of-products form,
// and the group generate/propagate pair for the next level.
// Assumes propagate is the OR of the operand bits.
module lasub_cla_group
    import lasub_pkg::*;
(
    input  grp_vec_t g_i,
    input  grp_vec_t p_i,
    input  logic     cin_i,
    output logic [GRP_W-2:0] c_o,   // c_o[j] is the carry into bit j+1
    output logic     gg_o,
    output logic     gp_o
);

    // Inner carries, each a two-level expression of g, p and cin.
    always_comb begin
        for (int j = 0; j < GRP_W - 1; j++) begin
            c_o[j] = flat_carry(g_i, p_i, cin_i, j);
        end
    end

    // Group generate ignores cin; group propagate is all bits propagating.
    always_comb begin
        gg_o = flat_carry(g_i, p_i, 1'b0, GRP_W - 1);
        gp_o = &p_i;
    end

endmodule

// File: rtl/lasub_carry_net.sv
// Carry network: per-bit generate/propagate, one lookahead group per four
// bits, and a chain between groups through group generate/propagate.
// Assumes W is a multiple of GRP_W.
module lasub_carry_net
    import lasub_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] bx_i,
    input  logic         cin_i,
    output logic [W:0]   carry_o   // carry_o[i] is the carry into bit i
);

    localparam int NGRP = W / GRP_W;

    logic [W-1:0]  gen;
    logic [W-1:0]  prop;
    logic [NGRP:0] grp_c;
    logic [NGRP-1:0] grp_g;
    logic [NGRP-1:0] grp_p;

    // Per-bit generate and propagate terms.
    always_comb begin
        gen  = a_i & bx_i;
        prop = a_i | bx_i;
    end

    assign grp_c[0] = cin_i;

    genvar k;
    generate
        for (k = 0; k < NGRP; k++) begin : g_grp
            logic [GRP_W-2:0] inner;

            lasub_cla_group u_grp (
                .g_i   (gen[k*GRP_W +: GRP_W]),
                .p_i   (prop[k*GRP_W +: GRP_W]),
                .cin_i (grp_c[k]),
                .c_o   (inner),
                .gg_o  (grp_g[k]),
                .gp_o  (grp_p[k])
            );

            // Group-level carry to the next group.
            assign grp_c[k+1] = grp_g[k] | (grp_p[k] & grp_c[k]);

            // Place the group's carries into the full carry vector.
            assign carry_o[k*GRP_W]                 = grp_c[k];
            assign carry_o[k*GRP_W+1 +: GRP_W-1]    = inner;
        end
    endgenerate

    assign carry_o[W] = grp_c[NGRP];

endmodule

// File: rtl/lasub_cla_addsub.sv
// Top: two's-complement add / subtract / increment with lookahead carries.
// Outputs depend only on the present inputs. Overflow is the XOR of the
// two most significant carries. Assumes W is a positive multiple of 4.
module lasub_cla_addsub
    import lasub_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         inc_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);

    generate
        if (W < GRP_W || (W % GRP_W) != 0) begin : g_bad_width
            $error("lasub_cla_addsub: W must be a positive multiple of 4");
        end
    endgenerate

    logic [W-1:0] bx;
    logic         cin;
    logic [W:0]   carry;

    lasub_operand_prep #(.W(W)) u_prep (
        .b_i   (b_i),
        .sub_i (sub_i),
        .inc_i (inc_i),
        .bx_o  (bx),
        .cin_o (cin)
    );

    lasub_carry_net #(.W(W)) u_carry (
        .a_i     (a_i),
        .bx_i    (bx),
        .cin_i   (cin),
        .carry_o (carry)
    );

    // Sum bits, top carry and signed overflow.
    always_comb begin
        sum_o  = a_i ^ bx ^ carry[W-1:0];
        cout_o = carry[W];
        ovf_o  = carry[W] ^ carry[W-1];
    end

endmodule

// File: rtl/lasub_cla_addsub_chk.sv
// Checker: compares the lookahead result with plain arithmetic and the
// overflow flag with the operand sign rule. Bound to the top module.
module lasub_cla_addsub_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         sub_i,
    input logic         inc_i,
    input logic [W-1:0] sum_o,
    input logic         cout_o,
    input logic         ovf_o
);

    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    // Immediate checks on every change of inputs or outputs.
    always_comb begin
        if (!inc_i && !sub_i) begin
            p_add_r1: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
                else $error("R1 add mismatch");
            p_ovf_add_r3: assert (ovf_o == ((a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1])))
                else $error("R3 add overflow mismatch");
        end
        if (!inc_i && sub_i) begin
            p_sub_r2: assert (sum_o == a_i - b_i && cout_o == (a_i >= b_i))
                else $error("R2 subtract mismatch");
            p_ovf_sub_r3: assert (ovf_o == ((a_i[W-1] != b_i[W-1]) && (sum_o[W-1] != a_i[W-1])))
                else $error("R3 subtract overflow mismatch");
        end
        if (inc_i) begin
            p_inc_r4: assert (sum_o == a_i + 1'b1 && cout_o == (&a_i))
                else $error("R4 increment mismatch");
            p_inc_ovf_r6: assert (ovf_o == (a_i == MAX_POS))
                else $error("R6 increment overflow mismatch");
        end
    end

endmodule

bind lasub_cla_addsub lasub_cla_addsub_chk #(.W(W)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_i),
    .inc_i  (inc_i),
    .sum_o  (sum_o),
    .cout_o (cout_o),
    .ovf_o  (ovf_o)
);

// File: tb/test_lasub_cla_addsub.sv
// Bench: directed table at W=16, exhaustive pairs at W=4, random wide vectors.
module test_lasub_cla_addsub;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int NW = 4;
    localparam int NVEC = 14;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;

    logic [W-1:0] a, b, sum;
    logic sub, inc, cout, ovf;
    logic [NW-1:0] na, nb, nsum;
    logic nsub, ninc, ncout, novf;

    lasub_cla_addsub #(.W(W)) i_lasub_cla_addsub (
        .a_i(a), .b_i(b), .sub_i(sub), .inc_i(inc),
        .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
    );

    lasub_cla_addsub #(.W(NW)) i_lasub_cla_addsub_n4 (
        .a_i(na), .b_i(nb), .sub_i(nsub), .inc_i(ninc),
        .sum_o(nsum), .cout_o(ncout), .ovf_o(novf)
    );

    // Mode code: bit1 = inc, bit0 = sub.
    localparam logic [15:0] T_A [NVEC] = '{
        16'h0001, 16'h7FFF, 16'hFFFF, 16'h8000, 16'h0005, 16'h0003, 16'h8000,
        16'h7FFF, 16'hFFFF, 16'h7FFF, 16'h0010, 16'h0FFF, 16'h1234, 16'hAAAA};
    localparam logic [15:0] T_B [NVEC] = '{
        16'h0001, 16'h0001, 16'h0001, 16'h8000, 16'h0003, 16'h0005, 16'h0001,
        16'hFFFF, 16'h1234, 16'hFFFF, 16'h0005, 16'h0001, 16'h1234, 16'h5555};
    localparam logic [1:0] T_M [NVEC] = '{
        2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1,
        2'd1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1, 2'd0};
    localparam logic [15:0] T_S [NVEC] = '{
        16'h0002, 16'h8000, 16'h0000, 16'h0000, 16'h0002, 16'hFFFE, 16'h7FFF,
        16'h8000, 16'h0000, 16'h8000, 16'h0011, 16'h1000, 16'h0000, 16'hFFFF};
    localparam logic T_C [NVEC] = '{
        1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
        1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic T_V [NVEC] = '{
        1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1,
        1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam string T_R [NVEC] = '{
        "R1", "R3", "R7", "R3", "R2", "R2", "R3",
        "R3", "R4", "R6", "R5", "R7", "R2", "R1"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Signed value of a W-bit pattern held in an int.
    function automatic int sval(input int v, input int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    // Independent reference: sum, carry and sign-rule overflow.
    task automatic ref_calc(input int w, input int av, input int bv, input int m,
                            output int es, output int ec, output int ev);
        int r;
        int mask;
        mask = (1 << w) - 1;
        if (m >= 2) begin
            es = (av + 1) & mask; ec = (av == mask); r = sval(av, w) + 1;
        end else if (m == 1) begin
            es = (av - bv) & mask; ec = (av >= bv); r = sval(av, w) - sval(bv, w);
        end else begin
            es = (av + bv) & mask; ec = ((av + bv) > mask); r = sval(av, w) + sval(bv, w);
        end
        ev = (r > sval(mask >> 1, w)) || (r < -(1 << (w - 1)));
    endtask

    task automatic apply_w(input logic [15:0] av, input logic [15:0] bv, input logic [1:0] m);
        @(negedge clk);
        a = av; b = bv; sub = m[0]; inc = m[1];
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int es, ec, ev;
        a = '0; b = '0; sub = 1'b0; inc = 1'b0;
        na = '0; nb = '0; nsub = 1'b0; ninc = 1'b0;
        repeat (2) @(posedge clk);

        // Idle inputs: zero operands give zero outputs (R1).
        @(negedge clk);
        chk("R1 idle sum", 32'(sum), 32'h0);
        chk("R1 idle cout", 32'(cout), 32'h0);
        chk("R3 idle ovf", 32'(ovf), 32'h0);

        // Directed table at W=16.
        for (int i = 0; i < NVEC; i++) begin
            apply_w(T_A[i], T_B[i], T_M[i]);
            chk({T_R[i], " table sum"}, 32'(sum), 32'(T_S[i]));
            chk({T_R[i], " table cout"}, 32'(cout), 32'(T_C[i]));
            chk({T_R[i], " table ovf"}, 32'(ovf), 32'(T_V[i]));
        end

        // Exhaustive pairs at W=4, add and subtract (R1 R2 R3 R8).
        for (int av = 0; av < 16; av++) begin
            for (int bv = 0; bv < 16; bv++) begin
                for (int m = 0; m < 2; m++) begin
                    @(negedge clk);
                    na = 4'(av); nb = 4'(bv); nsub = m[0]; ninc = 1'b0;
                    #1;
                    ref_calc(NW, av, bv, m, es, ec, ev);
                    chk(m ? "R2 n4 sum" : "R1 n4 sum", 32'(nsum), 32'(es));
                    chk(m ? "R2 n4 cout" : "R1 n4 cout", 32'(ncout), 32'(ec));
                    chk("R3 n4 ovf", 32'(novf), 32'(ev));
                end
            end
        end

        // Increment at W=4 with b held at an arbitrary value (R4 R5 R6 R8).
        for (int av = 0; av < 16; av++) begin
            @(negedge clk);
            na = 4'(av); nb = 4'(15 - av); nsub = av[0]; ninc = 1'b1;
            #1;
            ref_calc(NW, av, 0, 2, es, ec, ev);
            chk("R4 n4 inc sum", 32'(nsum), 32'(es));
            chk("R4 n4 inc cout", 32'(ncout), 32'(ec));
            chk("R6 n4 inc ovf", 32'(novf), 32'(ev));
        end

        // Random wide vectors in all modes (R1 R2 R3 R4 R7).
        for (int i = 0; i < 300; i++) begin
            int av, bv, m;
            av = int'($urandom_range(0, 65535));
            bv = int'($urandom_range(0, 65535));
            m  = int'($urandom_range(0, 2));
            apply_w(16'(av), 16'(bv), 2'(m));
            ref_calc(W, av, bv, m, es, ec, ev);
            chk("R7 rand sum", 32'(sum), 32'(es));
            chk("R2 rand cout", 32'(cout), 32'(ec));
            chk("R3 rand ovf", 32'(ovf), 32'(ev));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule